// File: doc/BRIEF.md
# Streaming Top-K Winner Selector

This block picks the k best-scoring nodes out of a stream of (node index, score) pairs. That operation is a k-winners-take-all filter. The scores arrive one pair at a time over a valid/ready handshake. The block keeps a short list of the best candidates in descending score order. When a new pair arrives, it is either rejected or moved into the right place in the list. The full score vector is never stored. Once the pair marked as the last one has been handled, the block streams out the winning node indices, best first. It then raises a one-cycle completion pulse and starts again with an empty list.

The block can also combine results from a partitioned problem. Each partition first produces its own list of up to k winners. Those lists are joined end to end and fed through the block again. The second pass selects the overall top k from all the candidates.

Top module: `topk_top`

## Requirements
- R1: Winner indices come out in descending order of score. Each one belongs to one of the k highest scores in the stream.
- R2: Suppose the list already holds k entries and a new score is not strictly greater than the smallest stored score. The pair is then rejected after one comparison, and `in_ready` is high again on the next cycle.
- R3: A score strictly greater than the smallest stored score is placed at its sorted position. The previous smallest entry is dropped.
- R4: Each clock performs at most one score comparison. Accepting a pair that is then inserted holds `in_ready` low for s+1 cycles. Here s is the number of stored entries the new pair climbs past.
- R5: A stream of n pairs yields min(n, k) output indices. `out_last` is high on the final one, so a stream of at least k pairs yields exactly k indices.
- R6: Feeding the concatenated local winner lists of several partitions through the block gives the same indices as selecting from all of the partitions' pairs together.
- R7: On equal scores the earlier arrival ranks higher. A later pair with a tied score never displaces a stored entry.
- R8: The list is empty after reset and after each completed stream. While fewer than k entries are stored, every arriving pair is kept.
- R9: While `out_valid` is high and `out_ready` is low, `out_idx` and `out_last` stay unchanged. `done` is high for exactly one cycle, the cycle after the final index is accepted. `in_ready` stays low from the last input until that cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pair is present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_idx | input | IDX_W | Node index of the pair |
| in_sum | input | SUM_W | Unsigned score of the pair |
| in_last | input | 1 | Marks the final pair of a stream |
| out_valid | output | 1 | A winner index is presented |
| out_ready | input | 1 | Consumer takes the index |
| out_idx | output | IDX_W | Winner node index, best first |
| out_last | output | 1 | Marks the final winner |
| done | output | 1 | One-cycle pulse after the final winner is taken |

## Verification
The bench builds the block with K=4, IDX_W=6 and SUM_W=8. With only four slots, a short stream is enough to fill the list, reach the deepest climb of three shifts, and push the tail out many times. The narrow score range is used with random draws up to 31, so ties at the cutoff occur often in random streams. It also keeps three eight-pair partitions plus a merged pass of twelve candidates quick to run. Streams shorter than K, including a single pair, exercise the partial list.

// File: rtl/topk_pkg.sv
package topk_pkg;

  typedef enum logic [1:0] {
    ST_TAKE = 2'd0,
    ST_CLIMB = 2'd1,
    ST_SEND = 2'd2,
    ST_FIN = 2'd3
  } topk_state_e;

endpackage

// File: rtl/topk_list.sv
module topk_list #(
  parameter int K = 4,
  parameter int IDX_W = 6,
  parameter int SUM_W = 8,
  parameter int PW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             wr_en,
  input  logic [PW-1:0]    pos,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SUM_W-1:0] wr_sum,
  input  logic [PW-1:0]    rd_pos,
  output logic [IDX_W-1:0] rd_idx,
  output logic [SUM_W-1:0] tail_sum,
  output logic [SUM_W-1:0] above_sum
);

  logic [IDX_W-1:0] idx_q [K];
  logic [SUM_W-1:0] sum_q [K];

  for (genvar g = 0; g < K; g++) begin : g_slot
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          idx_q[g] <= '0;
          sum_q[g] <= '0;
        end else if (wr_en && pos == PW'(g)) begin
          idx_q[g] <= wr_idx;
          sum_q[g] <= wr_sum;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          idx_q[g] <= '0;
          sum_q[g] <= '0;
        end else if (wr_en && pos == PW'(g)) begin
          idx_q[g] <= wr_idx;
          sum_q[g] <= wr_sum;
        end else if (shift_en && pos == PW'(g)) begin
          idx_q[g] <= idx_q[g-1];
          sum_q[g] <= sum_q[g-1];
        end
      end
    end
  end

  assign rd_idx    = idx_q[rd_pos];
  assign tail_sum  = sum_q[K-1];
  assign above_sum = (pos == '0) ? '0 : sum_q[pos - 1'b1];

endmodule

// File: rtl/topk_ctrl.sv
module topk_ctrl
  import topk_pkg::*;
#(
  parameter int K = 4,
  parameter int IDX_W = 6,
  parameter int SUM_W = 8,
  parameter int PW = 2,
  parameter int CW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [SUM_W-1:0] in_sum,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_last,
  output logic             done,
  input  logic [SUM_W-1:0] tail_sum,
  input  logic [SUM_W-1:0] above_sum,
  output logic             shift_en,
  output logic             wr_en,
  output logic [PW-1:0]    pos,
  output logic [PW-1:0]    rd_pos,
  output logic [IDX_W-1:0] cand_idx,
  output logic [SUM_W-1:0] cand_sum,
  output logic             ev_discard,
  output logic             ev_start,
  output logic             ev_shift,
  output logic             ev_place
);

  function automatic logic beats(input logic [SUM_W-1:0] a, input logic [SUM_W-1:0] b);
    return a > b;
  endfunction

  topk_state_e      state_q;
  logic [CW-1:0]    cnt_q;
  logic [PW-1:0]    pos_q;
  logic [PW-1:0]    optr_q;
  logic [IDX_W-1:0] cidx_q;
  logic [SUM_W-1:0] csum_q;
  logic             last_q;
  logic             full;
  logic             ev_accept;
  logic             climb;

  assign full       = (cnt_q == CW'(K));
  assign in_ready   = (state_q == ST_TAKE);
  assign ev_accept  = in_valid && in_ready;
  assign ev_discard = ev_accept && full && !beats(in_sum, tail_sum);
  assign ev_start   = ev_accept && !ev_discard;
  assign climb      = (state_q == ST_CLIMB) && (pos_q != '0) && beats(csum_q, above_sum);
  assign ev_shift   = climb;
  assign ev_place   = (state_q == ST_CLIMB) && !climb;
  assign out_valid  = (state_q == ST_SEND);
  assign out_last   = (CW'(optr_q) + CW'(1)) == cnt_q;
  assign done       = (state_q == ST_FIN);

  assign shift_en = ev_shift;
  assign wr_en    = ev_place;
  assign pos      = pos_q;
  assign rd_pos   = optr_q;
  assign cand_idx = cidx_q;
  assign cand_sum = csum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TAKE;
      cnt_q   <= '0;
      pos_q   <= '0;
      optr_q  <= '0;
      cidx_q  <= '0;
      csum_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_TAKE: begin
          optr_q <= '0;
          if (ev_discard) begin
            state_q <= in_last ? ST_SEND : ST_TAKE;
          end else if (ev_start) begin
            cidx_q  <= in_idx;
            csum_q  <= in_sum;
            last_q  <= in_last;
            pos_q   <= full ? PW'(K - 1) : PW'(cnt_q);
            if (!full) cnt_q <= cnt_q + CW'(1);
            state_q <= ST_CLIMB;
          end
        end
        ST_CLIMB: begin
          optr_q <= '0;
          if (climb) pos_q <= pos_q - PW'(1);
          else       state_q <= last_q ? ST_SEND : ST_TAKE;
        end
        ST_SEND: begin
          if (out_ready) begin
            if (out_last) state_q <= ST_FIN;
            else          optr_q  <= optr_q + PW'(1);
          end
        end
        default: begin
          cnt_q   <= '0;
          state_q <= ST_TAKE;
        end
      endcase
    end
  end

endmodule

// File: rtl/topk_top.sv
module topk_top #(
  parameter int K = 4,
  parameter int IDX_W = 6,
  parameter int SUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [SUM_W-1:0] in_sum,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] out_idx,
  output logic             out_last,
  output logic             done
);

  localparam int PW = (K > 1) ? $clog2(K) : 1;
  localparam int CW = $clog2(K + 1);

  logic             shift_en;
  logic             wr_en;
  logic [PW-1:0]    pos;
  logic [PW-1:0]    rd_pos;
  logic [IDX_W-1:0] cand_idx;
  logic [SUM_W-1:0] cand_sum;
  logic [SUM_W-1:0] tail_sum;
  logic [SUM_W-1:0] above_sum;
  logic             ev_discard;
  logic             ev_start;
  logic             ev_shift;
  logic             ev_place;

  topk_ctrl #(.K(K), .IDX_W(IDX_W), .SUM_W(SUM_W), .PW(PW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_idx(in_idx), .in_sum(in_sum), .in_last(in_last),
    .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_last(out_last), .done(done),
    .tail_sum(tail_sum), .above_sum(above_sum),
    .shift_en(shift_en), .wr_en(wr_en), .pos(pos), .rd_pos(rd_pos),
    .cand_idx(cand_idx), .cand_sum(cand_sum),
    .ev_discard(ev_discard), .ev_start(ev_start),
    .ev_shift(ev_shift), .ev_place(ev_place)
  );

  topk_list #(.K(K), .IDX_W(IDX_W), .SUM_W(SUM_W), .PW(PW)) u_list (
    .clk(clk), .rst_n(rst_n),
    .shift_en(shift_en), .wr_en(wr_en), .pos(pos),
    .wr_idx(cand_idx), .wr_sum(cand_sum),
    .rd_pos(rd_pos), .rd_idx(out_idx),
    .tail_sum(tail_sum), .above_sum(above_sum)
  );

endmodule

// File: rtl/topk_chk.sv
module topk_chk #(
  parameter int K = 4,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             in_last,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] out_idx,
  input logic             out_last,
  input logic             done,
  input logic             ev_discard,
  input logic             ev_start,
  input logic             ev_shift,
  input logic             ev_place
);

  localparam int BW = $clog2(K + 1);

  logic [BW-1:0] beat_q;
  logic [BW-1:0] climb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= '0;
      climb_q <= '0;
    end else begin
      if (done) beat_q <= '0;
      else if (out_valid && out_ready) beat_q <= beat_q + BW'(1);
      if (ev_place) climb_q <= '0;
      else if (ev_shift) climb_q <= climb_q + BW'(1);
    end
  end

  // R2: a rejected non-final pair frees the input on the next cycle
  a_r2_reject_resumes: assert property (@(posedge clk) disable iff (!rst_n)
    ev_discard && !in_last |=> in_ready);

  // R4: an insertion stalls the input
  a_r4_insert_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !in_ready);

  // R3: a pair climbs past at most K-1 entries
  a_r3_climb_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shift |-> climb_q < BW'(K - 1));

  // R5: never more than K winners
  a_r5_beats_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |-> beat_q < BW'(K));

  // R9: output held while stalled
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_idx) && $stable(out_last));

  // R9: completion follows the final winner
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> done);

  // R9: completion is a single-cycle pulse, then input reopens
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && in_ready);

  // R9: no input accepted while winners are sent
  a_r9_send_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

endmodule

bind topk_top topk_chk #(.K(K), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_topk_top.sv
module tb_topk_top;

  localparam int K = 4;
  localparam int IDX_W = 6;
  localparam int SUM_W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT = 100000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [IDX_W-1:0] in_idx = '0;
  logic [SUM_W-1:0] in_sum = '0;
  logic             in_last = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [IDX_W-1:0] out_idx;
  logic             out_last;
  logic             done;

  always #(CLK_PERIOD / 2) clk = ~clk;

  topk_top #(.K(K), .IDX_W(IDX_W), .SUM_W(SUM_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx),
    .in_sum(in_sum), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
    .out_last(out_last), .done(done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit wd_hit = 1'b0;

  // behavioural model state
  int m_idx[$];
  int m_sum[$];
  int ph = 0;    // 0 take, 1 busy, 2 send, 3 finish
  int busy = 0;
  int optr = 0;
  bit lastp = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit v, input int id, input int s, input bit l,
                            input bit ordy, output bit acc);
    acc = 1'b0;
    case (ph)
      0: if (v) begin
        bit full;
        acc = 1'b1;
        full = (m_sum.size() == K);
        if (full && s <= m_sum[K-1]) begin
          ph = l ? 2 : 0;
          optr = 0;
        end else begin
          int sp;
          int j;
          sp = full ? K - 1 : m_sum.size();
          if (full) begin
            void'(m_idx.pop_back());
            void'(m_sum.pop_back());
          end
          j = 0;
          foreach (m_sum[q]) if (m_sum[q] >= s) j++;
          m_idx.insert(j, id);
          m_sum.insert(j, s);
          busy = sp - j + 1;
          lastp = l;
          ph = 1;
        end
      end
      1: begin
        busy--;
        if (busy == 0) begin
          ph = lastp ? 2 : 0;
          optr = 0;
        end
      end
      2: if (ordy) begin
        if (optr == m_idx.size() - 1) ph = 3;
        else optr++;
      end
      default: begin
        m_idx.delete();
        m_sum.delete();
        ph = 0;
      end
    endcase
  endtask

  // independent selection: highest score first, earliest arrival on ties
  function automatic void ref_top(input int sq[$], output int pos_q[$]);
    bit used[];
    used = new[sq.size()];
    pos_q.delete();
    for (int r = 0; r < K && r < sq.size(); r++) begin
      int best = -1;
      for (int i = 0; i < sq.size(); i++)
        if (!used[i] && (best < 0 || sq[i] > sq[best])) best = i;
      used[best] = 1'b1;
      pos_q.push_back(best);
    end
  endfunction

  task automatic run_stream(input int iq[$], input int sq[$], input string tag,
                            output int got[$]);
    int p = 0;
    bit fin = 1'b0;
    int expp[$];
    got.delete();
    while (!fin && !wd_hit) begin
      bit acc;
      bit saw_fin;
      @(negedge clk);
      cycles++;
      if (cycles > WD_LIMIT) begin
        wd_hit = 1'b1;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog in %s: actual %0d expected <%0d cycles", tag, cycles, WD_LIMIT);
        break;
      end
      chk("R4 in_ready", int'(in_ready), int'(ph == 0));
      chk("R9 out_valid", int'(out_valid), int'(ph == 2));
      chk("R9 done", int'(done), int'(ph == 3));
      if (ph == 2) begin
        chk("R1 out_idx", int'(out_idx), m_idx[optr]);
        chk("R5 out_last", int'(out_last), int'(optr == m_idx.size() - 1));
      end
      in_valid = (p < iq.size()) && ($urandom_range(3) != 0);
      if (p < iq.size()) begin
        in_idx = IDX_W'(iq[p]);
        in_sum = SUM_W'(sq[p]);
        in_last = (p == iq.size() - 1);
      end
      out_ready = ($urandom_range(2) != 0);
      if (out_valid && out_ready) got.push_back(int'(out_idx));
      saw_fin = (ph == 3);
      model_step(in_valid, iq[p < iq.size() ? p : 0], sq[p < iq.size() ? p : 0],
                 in_last, out_ready, acc);
      if (acc) p++;
      if (saw_fin) fin = 1'b1;
    end
    in_valid = 1'b0;
    ref_top(sq, expp);
    chk({tag, " count"}, got.size(), expp.size());
    foreach (expp[r]) chk({tag, " winner"}, (r < got.size()) ? got[r] : -1, iq[expp[r]]);
  endtask

  initial begin
    int iq[$];
    int sq[$];
    int got[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset in_ready", int'(in_ready), 1);
    chk("R8 reset out_valid", int'(out_valid), 0);
    chk("R8 reset done", int'(done), 0);

    // R3: rising scores, each climbs to the head
    iq.delete(); sq.delete();
    for (int i = 0; i < 10; i++) begin iq.push_back(i); sq.push_back(10 + 5 * i); end
    run_stream(iq, sq, "R3 ascending", got);

    // R2: falling scores, later pairs rejected
    iq.delete(); sq.delete();
    for (int i = 0; i < 10; i++) begin iq.push_back(i + 20); sq.push_back(200 - 7 * i); end
    run_stream(iq, sq, "R2 descending", got);

    // R7: all ties, earliest K win
    iq.delete(); sq.delete();
    for (int i = 0; i < 8; i++) begin iq.push_back(40 + i); sq.push_back(50); end
    run_stream(iq, sq, "R7 ties", got);

    // R8: short streams keep everything
    iq.delete(); sq.delete();
    iq.push_back(3); sq.push_back(9); iq.push_back(5); sq.push_back(30);
    run_stream(iq, sq, "R8 short", got);
    iq.delete(); sq.delete();
    iq.push_back(17); sq.push_back(0);
    run_stream(iq, sq, "R8 single", got);

    // R1: random streams with frequent ties
    for (int t = 0; t < 4; t++) begin
      iq.delete(); sq.delete();
      for (int i = 0; i < 30; i++) begin iq.push_back(i); sq.push_back($urandom_range(31)); end
      run_stream(iq, sq, "R1 random", got);
    end

    // R6: partitioned selection and merged pass
    begin
      int all_i[$];
      int all_s[$];
      int mi[$];
      int ms[$];
      int gpos[$];
      for (int part = 0; part < 3; part++) begin
        int lpos[$];
        iq.delete(); sq.delete();
        for (int i = 0; i < 8; i++) begin
          iq.push_back(part * 8 + i);
          sq.push_back($urandom_range(63));
        end
        run_stream(iq, sq, "R6 partition", got);
        ref_top(sq, lpos);
        foreach (lpos[r]) begin mi.push_back(iq[lpos[r]]); ms.push_back(sq[lpos[r]]); end
        foreach (iq[r]) begin all_i.push_back(iq[r]); all_s.push_back(sq[r]); end
      end
      run_stream(mi, ms, "R6 merged", got);
      ref_top(all_s, gpos);
      foreach (gpos[r]) chk("R6 global", (r < got.size()) ? got[r] : -1, all_i[gpos[r]]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule